// File: doc/BRIEF.md
# Quad I/O Serial Flash Read Engine

This block is the host side of a serial flash read link. It runs one fast read with four data lines per request. A client hands it a start address, a byte count, an address-width choice (24 or 32 bits) and a flag that says whether the flash is in full quad mode. The request uses a valid/ready handshake. The engine then lowers chip select and clocks out the command. Next come the address nibbles and a fixed number of turnaround clocks. After that it collects nibbles from the flash and delivers whole bytes on a valid/ready output stream.

The serial clock comes from the system clock, divided by an even ratio. The clock rests low whenever chip select is high. The four data lines appear as separate output, output-enable and input vectors, so the pad ring can build the tristate buffers. A read ends in one of two ways: the requested number of bytes has arrived, or the client has pulsed a stop input. In both cases the transfer stops on a byte boundary. A slow consumer does not cause lost data: the engine holds the serial clock until the consumer has taken the byte.

Top module: `qspi_quad_reader`

## Requirements
- R1: `req_ready` is 1 only when no transaction is running and no byte is waiting on the output. A request is taken on a clock where `req_valid` and `req_ready` are both 1. On the next clock `cs_n` is 0 and `req_ready` is 0.
- R2: The first bits sent are the command byte 0xEB, most significant bit first.
  - When `req_quad_cmd`=0 it takes 8 serial clocks. Each bit is on `dq_out[0]` and `dq_oe`=4'b0001.
  - When `req_quad_cmd`=1 it takes 2 serial clocks of one nibble each, with `dq_oe`=4'b1111.
- R3: The address follows as nibbles, one per serial clock, with `dq_oe`=4'b1111. Nibble bit 3 is on `dq_out[3]`, and the most significant nibble goes first.
  - When `req_addr4`=0, bits 23:0 of `req_addr` are sent in 6 clocks.
  - When `req_addr4`=1, all 32 bits are sent in 8 clocks.
- R4: Six dummy clocks follow the address, with `dq_oe`=4'b0000. `dq_oe` stays 4'b0000 for the whole data phase.
- R5: Read nibbles are sampled from `dq_in` at the rising serial clock edge. The first nibble of each pair is bits 7:4 of the byte, and the second is bits 3:0. Bytes appear on `dout_data` in address order.
- R6: `sck` has a period of `SCK_DIV` system clocks while it runs. `sck` is 0 whenever `cs_n` is 1, and `cs_n` changes only while `sck` is 0.
- R7: A request with `req_len`=N returns N+1 bytes and then raises `cs_n`. The transaction then has exactly (command clocks + address clocks + 6 + 2·(N+1)) rising `sck` edges.
- R8: A one-cycle `stop_req` pulse while `cs_n` is 0 ends the transfer as soon as the byte in progress is complete. At least one byte is always returned.
- R9: While `dout_valid` is 1 and `dout_ready` is 0, `dout_data` holds steady and `sck` is held high before the next nibble. No byte is dropped or overwritten.
- R10: While `rst_n` is 0, `cs_n`=1, `sck`=0, `dq_oe`=0 and `dout_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Engine can take a request |
| req_addr | input | 32 | Start byte address |
| req_len | input | LEN_W | Byte count minus one |
| req_addr4 | input | 1 | 1: 32-bit address, 0: 24-bit address |
| req_quad_cmd | input | 1 | 1: command on four lines, 0: command on one line |
| stop_req | input | 1 | End the read at the next byte boundary |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| dq_out | output | 4 | Values driven onto the four data lines |
| dq_oe | output | 4 | Per-line output enable |
| dq_in | input | 4 | Values read from the four data lines |
| dout_data | output | 8 | Read byte |
| dout_valid | output | 1 | Read byte present |
| dout_ready | input | 1 | Consumer takes the byte |

## Verification
The bench pairs the engine with a behavioural flash model. The model decodes the command and the address from the lines and answers with data computed from the address. The test set covers all four combinations of command width and address width. It includes a single-byte read and an address that carries bits above 23 in 24-bit mode. A design that mixed up the nibble order, the bit order or the clock counts would show a wrong decoded opcode or address, or a wrong number of rising edges. Other test cases starve the output stream and stop the read both in the address phase and during a stall. A design that kept clocking under back-pressure would lose or overwrite bytes. One that stopped in the middle of a byte would return the wrong byte count. One that accepted a new request before the last byte was taken would violate the ready check.

// File: rtl/qrd_pkg.sv
package qrd_pkg;
  localparam logic [7:0] QRD_OPCODE = 8'hEB;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD   = 3'd1,
    ST_ADDR  = 3'd2,
    ST_DUMMY = 3'd3,
    ST_DATA  = 3'd4
  } qrd_state_e;
endpackage

// File: rtl/qrd_clkgen.sv
module qrd_clkgen #(
  parameter int SCK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold,
  output logic sck,
  output logic rise,
  output logic fall
);
  localparam int HALF = SCK_DIV / 2;
  localparam int PH_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [PH_W-1:0] ph_q, ph_d;
  logic            sck_d;
  logic            tick;

  assign tick = (ph_q == PH_W'(HALF - 1));
  assign rise = run && tick && !sck;
  assign fall = run && tick && sck && !hold;

  always_comb begin
    ph_d  = ph_q;
    sck_d = sck;
    if (!run) begin
      ph_d  = '0;
      sck_d = 1'b0;
    end else if (rise || fall) begin
      ph_d  = '0;
      sck_d = !sck;
    end else if (!tick) begin
      ph_d = ph_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      sck  <= 1'b0;
    end else begin
      ph_q <= ph_d;
      sck  <= sck_d;
    end
  end

  // R9: a held clock stays high
  p_pause_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sck && hold) |=> sck);
endmodule

// File: rtl/qrd_rxbuf.sv
module qrd_rxbuf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap,
  input  logic       nib,
  input  logic [3:0] dq_in,
  input  logic       dout_ready,
  output logic [7:0] dout_data,
  output logic       dout_valid
);
  logic [3:0] hi_q, hi_d;
  logic [7:0] data_d;
  logic       valid_d;

  always_comb begin
    hi_d    = hi_q;
    data_d  = dout_data;
    valid_d = dout_valid;
    if (dout_valid && dout_ready) valid_d = 1'b0;
    if (cap) begin
      if (!nib) begin
        hi_d = dq_in;
      end else begin
        data_d  = {hi_q, dq_in};
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q       <= '0;
      dout_data  <= '0;
      dout_valid <= 1'b0;
    end else begin
      hi_q       <= hi_d;
      dout_data  <= data_d;
      dout_valid <= valid_d;
    end
  end

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

  p_no_overwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && nib) |-> (!dout_valid || dout_ready));
endmodule

// File: rtl/qrd_seq.sv
module qrd_seq
  import qrd_pkg::*;
#(
  parameter int DUMMY_CLKS = 6,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_addr4,
  input  logic             req_quad_cmd,
  input  logic             stop_req,
  input  logic             rise,
  input  logic             fall,
  input  logic             buf_full,
  input  logic             dout_ready,
  output logic             cs_n,
  output logic [3:0]       dq_out,
  output logic [3:0]       dq_oe,
  output logic             cap,
  output logic             nib,
  output logic             hold
);
  localparam int MAXS  = (DUMMY_CLKS > 8) ? DUMMY_CLKS : 8;
  localparam int CNT_W = $clog2(MAXS);

  qrd_state_e       st_q, st_d;
  logic [39:0]      sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             nib_q, nib_d;
  logic             stop_q, stop_d;
  logic             quad_q, quad_d;
  logic             a4_q, a4_d;
  logic             cs_n_d;
  logic             accept, ending, ser, drive;

  assign req_ready = (st_q == ST_IDLE) && !buf_full;
  assign accept    = req_valid && req_ready;
  assign ending    = (st_q == ST_DATA) && nib_q && ((rem_q == '0) || stop_q);
  assign hold      = (st_q == ST_DATA) && buf_full && !dout_ready && !ending;
  assign cap       = rise && (st_q == ST_DATA);
  assign nib       = nib_q;
  assign ser       = (st_q == ST_CMD) && !quad_q;
  assign drive     = (st_q == ST_CMD) || (st_q == ST_ADDR);
  assign dq_out    = ser ? {3'b000, sh_q[39]} : (drive ? sh_q[39:36] : 4'b0000);
  assign dq_oe     = ser ? 4'b0001 : (drive ? 4'b1111 : 4'b0000);

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    nib_d  = nib_q;
    stop_d = stop_q;
    quad_d = quad_q;
    a4_d   = a4_q;
    cs_n_d = cs_n;
    if (!cs_n && stop_req) stop_d = 1'b1;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_CMD;
          cs_n_d = 1'b0;
          sh_d   = {QRD_OPCODE, req_addr4 ? req_addr : {req_addr[23:0], 8'h00}};
          cnt_d  = req_quad_cmd ? CNT_W'(1) : CNT_W'(7);
          rem_d  = req_len;
          nib_d  = 1'b0;
          stop_d = 1'b0;
          quad_d = req_quad_cmd;
          a4_d   = req_addr4;
        end
      end
      ST_CMD: begin
        if (fall) begin
          sh_d = quad_q ? (sh_q << 4) : (sh_q << 1);
          if (cnt_q == '0) begin
            st_d  = ST_ADDR;
            cnt_d = a4_q ? CNT_W'(7) : CNT_W'(5);
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      ST_ADDR: begin
        if (fall) begin
          sh_d = sh_q << 4;
          if (cnt_q == '0) begin
            st_d  = ST_DUMMY;
            cnt_d = CNT_W'(DUMMY_CLKS - 1);
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      ST_DUMMY: begin
        if (fall) begin
          if (cnt_q == '0) begin
            st_d  = ST_DATA;
            nib_d = 1'b0;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      ST_DATA: begin
        if (fall) begin
          if (ending) begin
            st_d   = ST_IDLE;
            cs_n_d = 1'b1;
          end else begin
            nib_d = !nib_q;
            if (nib_q) rem_d = rem_q - LEN_W'(1);
          end
        end
      end
      default: begin
        st_d   = ST_IDLE;
        cs_n_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      rem_q  <= '0;
      nib_q  <= 1'b0;
      stop_q <= 1'b0;
      quad_q <= 1'b0;
      a4_q   <= 1'b0;
      cs_n   <= 1'b1;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      nib_q  <= nib_d;
      stop_q <= stop_d;
      quad_q <= quad_d;
      a4_q   <= a4_d;
      cs_n   <= cs_n_d;
    end
  end

  p_ready_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);

  p_accept_selects_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !cs_n);
endmodule

// File: rtl/qspi_quad_reader.sv
module qspi_quad_reader #(
  parameter int SCK_DIV    = 4,
  parameter int DUMMY_CLKS = 6,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_addr4,
  input  logic             req_quad_cmd,
  input  logic             stop_req,
  output logic             cs_n,
  output logic             sck,
  output logic [3:0]       dq_out,
  output logic [3:0]       dq_oe,
  input  logic [3:0]       dq_in,
  output logic [7:0]       dout_data,
  output logic             dout_valid,
  input  logic             dout_ready
);
  logic rise, fall, hold, cap, nib;

  qrd_clkgen #(.SCK_DIV(SCK_DIV)) u_clk (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (!cs_n),
    .hold (hold),
    .sck  (sck),
    .rise (rise),
    .fall (fall)
  );

  qrd_seq #(.DUMMY_CLKS(DUMMY_CLKS), .LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .req_addr4   (req_addr4),
    .req_quad_cmd(req_quad_cmd),
    .stop_req    (stop_req),
    .rise        (rise),
    .fall        (fall),
    .buf_full    (dout_valid),
    .dout_ready  (dout_ready),
    .cs_n        (cs_n),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe),
    .cap         (cap),
    .nib         (nib),
    .hold        (hold)
  );

  qrd_rxbuf u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (cap),
    .nib       (nib),
    .dq_in     (dq_in),
    .dout_ready(dout_ready),
    .dout_data (dout_data),
    .dout_valid(dout_valid)
  );

  p_idle_sck_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  p_select_edge_sck_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sck);

  p_bus_released_on_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_valid) |-> (dq_oe == 4'b0000));
endmodule

// File: tb/qspi_quad_reader_test.sv
`timescale 1ns/1ps
module qspi_quad_reader_test;
  localparam int SCK_DIV = 4;
  localparam int NDUMMY  = 6;
  localparam int LEN_W   = 16;
  localparam real TCLK   = 4.0;

  typedef struct packed {
    logic [31:0] addr;
    logic [7:0]  len;
    logic        a4;
    logic        qc;
    logic [1:0]  rmode;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0012_3456, 8'd3, 1'b0, 1'b0, 2'd0},
    '{32'h89AB_CDEF, 8'd4, 1'b1, 1'b0, 2'd0},
    '{32'h00FF_FFFE, 8'd3, 1'b0, 1'b1, 2'd0},
    '{32'hF0E1_D2C3, 8'd0, 1'b1, 1'b1, 2'd0},
    '{32'h7654_3210, 8'd7, 1'b1, 1'b0, 2'd1},
    '{32'hAB00_0010, 8'd5, 1'b0, 1'b1, 2'd1}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [31:0]      req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             req_addr4 = 1'b0;
  logic             req_quad_cmd = 1'b0;
  logic             stop_req = 1'b0;
  logic             cs_n, sck;
  logic [3:0]       dq_out, dq_oe;
  logic [3:0]       dq_in_r = 4'h0;
  logic [7:0]       dout_data;
  logic             dout_valid;
  logic             dout_ready = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(TCLK/2) clk = ~clk;

  qspi_quad_reader #(.SCK_DIV(SCK_DIV), .DUMMY_CLKS(NDUMMY), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_addr4(req_addr4),
    .req_quad_cmd(req_quad_cmd), .stop_req(stop_req), .cs_n(cs_n), .sck(sck),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in_r), .dout_data(dout_data),
    .dout_valid(dout_valid), .dout_ready(dout_ready)
  );

  function automatic logic [7:0] memb(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h96;
  endfunction

  // flash model configuration, set by the bench before each request
  logic cfg_quad = 1'b0;
  logic cfg_a4   = 1'b0;
  int          m_edges = 0;
  logic [7:0]  m_op = '0;
  logic [31:0] m_addr = '0;
  int          m_bad_oe = 0;

  always @(posedge sck or negedge cs_n) begin
    int ce, ae;
    ce = cfg_quad ? 2 : 8;
    ae = cfg_a4 ? 8 : 6;
    if (!sck) begin
      m_edges  = 0;
      m_op     = '0;
      m_addr   = '0;
      m_bad_oe = 0;
    end else if (!cs_n) begin
      m_edges = m_edges + 1;
      if (m_edges <= ce) begin
        m_op = cfg_quad ? {m_op[3:0], dq_out} : {m_op[6:0], dq_out[0]};
        if (dq_oe != (cfg_quad ? 4'hF : 4'h1)) m_bad_oe = m_bad_oe + 1;
      end else if (m_edges <= ce + ae) begin
        m_addr = {m_addr[27:0], dq_out};
        if (dq_oe != 4'hF) m_bad_oe = m_bad_oe + 1;
      end else if (dq_oe != 4'h0) begin
        m_bad_oe = m_bad_oe + 1;
      end
    end
  end

  always @(negedge sck) begin
    int ce, ae, j;
    logic [31:0] a;
    logic [7:0]  b;
    ce = cfg_quad ? 2 : 8;
    ae = cfg_a4 ? 8 : 6;
    if (!cs_n && m_edges >= ce + ae + NDUMMY) begin
      j = m_edges - (ce + ae + NDUMMY);
      a = m_addr + 32'(j / 2);
      if (!cfg_a4) a = a & 32'h00FF_FFFF;
      b = memb(a);
      dq_in_r = (j % 2 == 0) ? b[7:4] : b[3:0];
    end
  end

  realtime last_rise = 0.0;
  realtime sck_period = 0.0;
  always @(posedge sck) begin
    sck_period = $realtime - last_rise;
    last_rise  = $realtime;
  end

  // consumer: ready pattern chosen by ready_mode, bytes collected
  int ready_mode = 0;
  int rcnt = 0;
  logic [7:0] rx_q[$];
  always @(negedge clk) begin
    logic r;
    rcnt = rcnt + 1;
    r = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? (rcnt % 4 == 3) : 1'b0;
    dout_ready = r;
    if (dout_valid && r) rx_q.push_back(dout_data);
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] addr, input int len, input bit a4, input bit qc);
    cfg_a4 = a4;
    cfg_quad = qc;
    while (!req_ready) @(negedge clk);
    req_addr = addr;
    req_len = LEN_W'(len);
    req_addr4 = a4;
    req_quad_cmd = qc;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!cs_n && !req_ready, "R1 accept lowers cs_n and ready", {cs_n, req_ready}, 2'b00);
  endtask

  task automatic finish_txn;
    while (!cs_n) @(negedge clk);
    while (dout_valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_bytes(input int base, input logic [31:0] ea, input bit a4, input int n, input string tag);
    int bad;
    logic [7:0] e, g;
    bad = 0;
    e = '0;
    g = '0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] a;
      a = ea + 32'(i);
      if (!a4) a = a & 32'h00FF_FFFF;
      if (base + i < rx_q.size()) begin
        if (rx_q[base + i] != memb(a) && bad == 0) begin
          e = memb(a);
          g = rx_q[base + i];
          bad = 1;
        end
      end
    end
    chk(bad == 0, tag, g, e);
  endtask

  task automatic run_vec(input vec_t v);
    int base, ce, ae, n;
    logic [31:0] ea;
    ready_mode = int'(v.rmode);
    base = rx_q.size();
    issue(v.addr, int'(v.len), v.a4, v.qc);
    finish_txn();
    ce = v.qc ? 2 : 8;
    ae = v.a4 ? 8 : 6;
    n  = int'(v.len) + 1;
    ea = v.a4 ? v.addr : {8'h00, v.addr[23:0]};
    chk(m_op == 8'hEB, "R2 opcode seen by flash", m_op, 8'hEB);
    chk(m_addr == ea, "R3 address seen by flash", m_addr, ea);
    chk(m_bad_oe == 0, "R4 output enable per phase", m_bad_oe, 0);
    chk(m_edges == ce + ae + NDUMMY + 2 * n, "R7 rising sck edge count", m_edges, ce + ae + NDUMMY + 2 * n);
    chk(rx_q.size() - base == n, "R7 byte count", rx_q.size() - base, n);
    check_bytes(base, ea, v.a4, n, v.rmode != 0 ? "R9 bytes under back-pressure" : "R5 byte values");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cs_n && !sck && dq_oe == 4'h0 && !dout_valid, "R10 outputs in reset",
        {cs_n, sck, dq_oe, dout_valid}, {1'b1, 1'b0, 4'h0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    foreach (VECS[k]) begin
      run_vec(VECS[k]);
      if (k == 0) begin
        chk(sck_period == SCK_DIV * TCLK, "R6 sck period",
            64'(int'(sck_period)), 64'(int'(SCK_DIV * TCLK)));
        chk(cs_n && !sck, "R6 sck low when idle", {cs_n, sck}, 2'b10);
      end
    end

    // R9 and R8: stall after the first byte, then stop
    ready_mode = 2;
    base = rx_q.size();
    issue(32'h0000_4321, 9, 1'b0, 1'b0);
    while (!dout_valid) @(negedge clk);
    repeat (3 * SCK_DIV) @(negedge clk);
    chk(sck && m_edges == 8 + 6 + NDUMMY + 2, "R9 sck paused high",
        {sck, 8'(m_edges)}, {1'b1, 8'(8 + 6 + NDUMMY + 2)});
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    repeat (2 * SCK_DIV) @(negedge clk);
    chk(cs_n && dout_valid && !req_ready, "R1 no request while byte waits",
        {cs_n, dout_valid, req_ready}, 3'b110);
    ready_mode = 0;
    finish_txn();
    chk(rx_q.size() - base == 1, "R8 stop during stall gives one byte", rx_q.size() - base, 1);
    check_bytes(base, 32'h0000_4321, 1'b0, 1, "R8 byte before stop");

    // R8: stop during address phase still yields one byte
    base = rx_q.size();
    issue(32'h0055_AA00, 6, 1'b0, 1'b0);
    while (m_edges < 10) @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    finish_txn();
    chk(rx_q.size() - base == 1, "R8 stop in address phase gives one byte", rx_q.size() - base, 1);
    chk(m_edges == 8 + 6 + NDUMMY + 2, "R8 edges after early stop", m_edges, 8 + 6 + NDUMMY + 2);
    check_bytes(base, 32'h0055_AA00, 1'b0, 1, "R8 byte value after early stop");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule